// File: doc/BRIEF.md
# Shared-Interval Digital Input Deglitch Filter

This block cleans up a bank of digital input lines grouped into 8-bit ports. Each line first passes through a two-stage synchronizer. It then either goes straight to its output or through a stability qualifier. A qualified line changes its output only after the synchronized input has held its new level for a programmed number of time-base ticks. All lines share one interval value. Each line has its own enable bit, kept in one enable byte per port. The time base is a 200 ns tick, made by a free-running prescaler of `TICK_CYCLES` clocks, so the interval is counted in 200 ns steps up to a 20-bit limit.

Software sets the block up through a simple write port and a combinational read port. The interval register sits at byte address 0x08. The enable byte of port p sits at 0x44 + 16*p, and bit b of that byte controls line 8*p + b. Writing an interval of 0, or clearing the enable bytes, puts every line back in plain pass-through.

Each line runs a three-state machine. `ST_PASS` is the bypass state: the output follows the synchronized input. It moves to `ST_STABLE` when the line is enabled and the interval is nonzero. `ST_STABLE` means the output matches the input. It moves to `ST_QUALIFY` when the input differs from the output. `ST_QUALIFY` counts ticks while the input keeps differing. It moves back to `ST_STABLE` in two cases: when the count reaches the interval, which updates the output, or when the input returns to the output level, which drops the count. Any state moves to `ST_PASS` when the line is disabled or the interval becomes 0.

Top module: `din_deglitch`

## Requirements
- R1: After reset, every output bit is 0, the interval register reads 0 and every enable byte reads 0.
- R2: A write to address 0x08 stores bits 19:0 of the write data as the shared interval. Bits 31:20 are discarded, and a read of 0x08 returns the stored value with bits 31:20 zero.
- R3: A write to address 0x44 + 16*p stores bits 7:0 of the write data as the enable byte of port p. Bit b enables filtering of line 8*p + b, and a read of the same address returns that byte in bits 7:0.
- R4: A line whose enable bit is 0 copies its input to its output with a fixed latency of 3 clock edges (two synchronizer stages plus the output register), whatever the interval value.
- R5: An enabled line with an interval of 0 behaves exactly as in R4.
- R6: An enabled line with interval N > 0 changes its output only on a tick, and only after its input has differed from its output for N ticks. Measured in clock edges from the input change, the output follows no earlier than (N-1)*TICK_CYCLES+4 and no later than N*TICK_CYCLES+3.
- R7: If the input returns to the output level before qualification, the output does not change and the tick count restarts from zero for the next change.
- R8: The prescaler produces a one-cycle tick every TICK_CYCLES clocks. Ticks are spaced exactly TICK_CYCLES cycles apart, and the first comes TICK_CYCLES-1 cycles after reset.
- R9: Clearing a line's enable bit while it is qualifying drops the pending count, and the output takes the input level within 3 edges of the write.
- R10: The single interval value applies to enabled lines on every port.
- R11: Writes to any other address change nothing, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | NUM_PORTS*8 | Raw asynchronous input lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | 32 | Register read data (combinational) |
| dout | output | NUM_PORTS*8 | Filtered output lines |

## Verification
A configuration write and the qualification of a line can fall in the same cycle. The case that matters is a line being disabled while it sits in `ST_QUALIFY` with part of its count done. The bench sets a long interval, changes the input, and checks that the output still holds the old level. It then clears the enable byte in the middle of the count and expects the output to take the new level within the pass-through latency, not at the end of the interval. A second overlap checks that a revert of the input and a tick in the same cycle never update the output: the bench sends pulses shorter than the interval and requires that no change reaches the output.

// File: rtl/dgf_pkg.sv
package dgf_pkg;

    localparam int DATA_W       = 32;
    localparam int PORT_W       = 8;
    localparam int ADDR_INTERVAL = 'h08;
    localparam int ADDR_EN_BASE  = 'h44;
    localparam int PORT_STRIDE   = 'h10;

    typedef enum logic [1:0] {
        ST_PASS    = 2'd0,
        ST_STABLE  = 2'd1,
        ST_QUALIFY = 2'd2
    } ch_state_t;

endpackage

// File: rtl/dgf_tick_gen.sv
module dgf_tick_gen #(
    parameter int TICK_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

endmodule

// File: rtl/dgf_sync.sv
module dgf_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/dgf_regs.sv
module dgf_regs
    import dgf_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int CNT_W     = 20,
    parameter int ADDR_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic [CNT_W-1:0]              intv,
    output logic [NUM_PORTS*PORT_W-1:0]   chan_en
);
    localparam logic [ADDR_W-1:0] A_INTV = ADDR_W'(ADDR_INTERVAL);

    logic [CNT_W-1:0]  intv_q;
    logic [PORT_W-1:0] en_q [NUM_PORTS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intv_q <= '0;
        end else if (wr_en && (wr_addr == A_INTV)) begin
            intv_q <= wr_data[CNT_W-1:0];
        end
    end

    genvar p;
    generate
        for (p = 0; p < NUM_PORTS; p++) begin : g_port
            localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(ADDR_EN_BASE + PORT_STRIDE * p);
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q[p] <= '0;
                end else if (wr_en && (wr_addr == A_EN)) begin
                    en_q[p] <= wr_data[PORT_W-1:0];
                end
            end
            assign chan_en[p*PORT_W +: PORT_W] = en_q[p];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_INTV) begin
            rd_data = DATA_W'(intv_q);
        end
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (rd_addr == ADDR_W'(ADDR_EN_BASE + PORT_STRIDE * i)) begin
                rd_data = DATA_W'(en_q[i]);
            end
        end
    end

    assign intv = intv_q;

endmodule

// File: rtl/dgf_channel.sv
module dgf_channel
    import dgf_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [CNT_W-1:0] intv,
    input  logic             sync_in,
    output logic             filt_out,
    output logic             filtering
);
    ch_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   cnt_inc;
    logic             out_q;
    logic             bypass;
    logic             diff;
    logic             expire;
    logic             load;

    always_comb begin
        bypass  = !en || (intv == '0);
        diff    = (sync_in != out_q);
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        expire  = tick && (cnt_inc >= {1'b0, intv});
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        unique case (state_q)
            ST_PASS: begin
                cnt_d = '0;
                if (!bypass) begin
                    state_d = ST_STABLE;
                end
            end
            ST_STABLE: begin
                cnt_d = '0;
                if (bypass) begin
                    state_d = ST_PASS;
                end else if (diff) begin
                    state_d = ST_QUALIFY;
                end
            end
            ST_QUALIFY: begin
                if (bypass) begin
                    state_d = ST_PASS;
                    cnt_d   = '0;
                end else if (!diff) begin
                    state_d = ST_STABLE;
                    cnt_d   = '0;
                end else if (expire) begin
                    state_d = ST_STABLE;
                    cnt_d   = '0;
                    load    = 1'b1;
                end else if (tick) begin
                    cnt_d = cnt_inc[CNT_W-1:0];
                end
            end
            default: begin
                state_d = ST_PASS;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (bypass || (state_q == ST_PASS) || load) begin
            out_q <= sync_in;
        end
    end

    assign filt_out  = out_q;
    assign filtering = (state_q != ST_PASS);

endmodule

// File: rtl/din_deglitch.sv
module din_deglitch
    import dgf_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int TICK_CYCLES = 20,
    parameter int CNT_W       = 20,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*8-1:0]      din,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [31:0]                 wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [31:0]                 rd_data,
    output logic [NUM_PORTS*8-1:0]      dout
);
    localparam int NUM_CH = NUM_PORTS * PORT_W;

    logic              tick;
    logic [NUM_CH-1:0] sync_q;
    logic [NUM_CH-1:0] chan_en;
    logic [NUM_CH-1:0] chan_filtering;
    logic [CNT_W-1:0]  intv_q;

    dgf_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    dgf_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(din),
        .sync_out(sync_q)
    );

    dgf_regs #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .intv   (intv_q),
        .chan_en(chan_en)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            dgf_channel #(.CNT_W(CNT_W)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick),
                .en       (chan_en[c]),
                .intv     (intv_q),
                .sync_in  (sync_q[c]),
                .filt_out (dout[c]),
                .filtering(chan_filtering[c])
            );
        end
    endgenerate

endmodule

// File: rtl/dgf_checker.sv
module dgf_checker
    import dgf_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int TICK_CYCLES = 20,
    parameter int CNT_W       = 20,
    parameter int ADDR_W      = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          tick,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [31:0]                   wr_data,
    input logic [CNT_W-1:0]              intv_q,
    input logic [NUM_PORTS*PORT_W-1:0]   chan_en,
    input logic [NUM_PORTS*PORT_W-1:0]   sync_q,
    input logic [NUM_PORTS*PORT_W-1:0]   chan_filtering,
    input logic [NUM_PORTS*PORT_W-1:0]   dout
);
    localparam int NUM_CH = NUM_PORTS * PORT_W;
    localparam int GW = $clog2(TICK_CYCLES + 1) + 1;

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (tick) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dout == '0) && (intv_q == '0) && (chan_en == '0));

    assert_interval_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADDR_W'(ADDR_INTERVAL))) |=> (intv_q == $past(wr_data[CNT_W-1:0])));

    assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q == GW'(TICK_CYCLES - 1)));

    genvar p;
    generate
        for (p = 0; p < NUM_PORTS; p++) begin : g_pchk
            assert_enable_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (wr_addr == ADDR_W'(ADDR_EN_BASE + PORT_STRIDE * p)))
                |=> (chan_en[p*PORT_W +: PORT_W] == $past(wr_data[PORT_W-1:0])));
        end
    endgenerate

    genvar i;
    generate
        for (i = 0; i < NUM_CH; i++) begin : g_cchk
            assert_disabled_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !chan_en[i] |=> (dout[i] == $past(sync_q[i])));

            assert_zero_interval_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (chan_en[i] && (intv_q == '0)) |=> (dout[i] == $past(sync_q[i])));

            assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (chan_filtering[i] && chan_en[i] && (intv_q != '0) && !tick) |=> $stable(dout[i]));

            assert_revert_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (chan_filtering[i] && (sync_q[i] == dout[i])) |=> $stable(dout[i]));
        end
    endgenerate

endmodule

bind din_deglitch dgf_checker #(
    .NUM_PORTS  (NUM_PORTS),
    .TICK_CYCLES(TICK_CYCLES),
    .CNT_W      (CNT_W),
    .ADDR_W     (ADDR_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .intv_q        (intv_q),
    .chan_en       (chan_en),
    .sync_q        (sync_q),
    .chan_filtering(chan_filtering),
    .dout          (dout)
);

// File: tb/din_deglitch_tb_top.sv
module din_deglitch_tb_top;

    localparam int NP = 4;
    localparam int NC = NP * 8;
    localparam int T  = 20;

    logic          clk;
    logic          rst_n;
    logic [NC-1:0] din;
    logic          wr_en;
    logic [7:0]    wr_addr;
    logic [31:0]   wr_data;
    logic [7:0]    rd_addr;
    logic [31:0]   rd_data;
    logic [NC-1:0] dout;

    int checks   = 0;
    int failures = 0;

    din_deglitch #(.NUM_PORTS(NP), .TICK_CYCLES(T)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (din),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .dout   (dout)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // {channel, enable, interval, pulse width (0 = sustained)}
    localparam int NV = 9;
    localparam int VEC [NV][4] = '{
        '{0,  0, 0, 0},
        '{5,  0, 9, 0},
        '{9,  1, 0, 0},
        '{1,  1, 4, 0},
        '{1,  1, 4, 40},
        '{27, 1, 4, 0},
        '{12, 1, 1, 0},
        '{20, 1, 2, 15},
        '{31, 1, 3, 0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 8'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic reg_read(input int addr, output logic [31:0] data);
        @(negedge clk);
        rd_addr = 8'(addr);
        #1;
        data = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Flip a line at a falling edge, count rising edges until the output follows.
    task automatic flip_and_time(input int ch, input int limit, output int k);
        logic nv;
        nv = ~dout[ch];
        din[ch] = nv;
        k = -1;
        for (int c = 1; c <= limit; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (dout[ch] == nv) begin
                k = c;
                break;
            end
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] rv;
        int k;
        rst_n   = 1'b0;
        din     = '0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        rd_addr = '0;
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        check(dout == '0, "R1 dout after reset", int'(dout), 0);
        reg_read('h08, rv);
        check(rv == 0, "R1 interval after reset", int'(rv), 0);
        for (int p = 0; p < NP; p++) begin
            reg_read('h44 + 16 * p, rv);
            check(rv == 0, "R1 enable byte after reset", int'(rv), 0);
        end

        // R2: interval width
        reg_write('h08, 32'hFFF1_2345);
        reg_read('h08, rv);
        check(rv == 32'h0001_2345, "R2 interval truncation", int'(rv), 'h12345);
        reg_write('h08, 32'hFFFF_FFFF);
        reg_read('h08, rv);
        check(rv == 32'h000F_FFFF, "R2 interval maximum", int'(rv), 'hFFFFF);

        // R11: unmapped addresses
        reg_write('h09, 32'h0000_0007);
        reg_write('h45, 32'h0000_00FF);
        reg_read('h08, rv);
        check(rv == 32'h000F_FFFF, "R11 stray write kept interval", int'(rv), 'hFFFFF);
        reg_read('h44, rv);
        check(rv == 0, "R11 stray write kept enable", int'(rv), 0);
        reg_read('h45, rv);
        check(rv == 0, "R11 unmapped read", int'(rv), 0);

        // R3: enable byte readback and line mapping (port 2: bit 3 on, bit 1 off)
        reg_write('h44 + 32, 32'hFFFF_FFA5 ^ 32'h0000_0008 ^ 32'h0000_0008);
        reg_read('h64, rv);
        check(rv == 32'h0000_00A5, "R3 enable readback", int'(rv), 'hA5);
        reg_write('h08, 4);
        reg_write('h64, 32'h0000_0008);
        idle(8);
        flip_and_time(17, 200, k);
        check(k == 3, "R3 line 17 not enabled passes", k, 3);
        flip_and_time(19, 200, k);
        check(k >= 3 * T + 4 && k <= 4 * T + 3, "R3 line 19 enabled filters", k, 4 * T);
        reg_write('h64, 0);

        // Vector walk: R4 R5 R6 R7 R8 R10
        for (int v = 0; v < NV; v++) begin
            int ch, en, n, pw, port;
            logic old;
            ch = VEC[v][0]; en = VEC[v][1]; n = VEC[v][2]; pw = VEC[v][3];
            port = ch / 8;
            reg_write('h08, 32'(n));
            reg_write('h44 + 16 * port, en ? (32'd1 << (ch % 8)) : 32'd0);
            idle(8);
            if (pw == 0) begin
                flip_and_time(ch, n * T + 60, k);
                if (!en) check(k == 3, "R4 disabled line latency", k, 3);
                else if (n == 0) check(k == 3, "R5 zero interval latency", k, 3);
                else if (ch >= 24) check(k >= (n - 1) * T + 4 && k <= n * T + 3,
                                         "R10 shared interval on port 3", k, n * T);
                else check(k >= (n - 1) * T + 4 && k <= n * T + 3,
                           "R6 R8 qualification window", k, n * T);
            end else begin
                bit seen;
                old = dout[ch];
                din[ch] = ~old;
                seen = 1'b0;
                for (int c = 1; c <= n * T + 40; c++) begin
                    @(posedge clk);
                    @(negedge clk);
                    if (c == pw) din[ch] = old;
                    if (dout[ch] != old) seen = 1'b1;
                end
                check(!seen, "R7 short pulse suppressed", int'(seen), 0);
            end
            reg_write('h44 + 16 * port, 0);
            idle(4);
        end

        // R7: count restarts after a revert
        reg_write('h08, 4);
        reg_write('h44, 32'h0000_0001);
        idle(8);
        begin
            logic old;
            old = dout[0];
            din[0] = ~old;
            idle(40);
            din[0] = old;
            idle(3);
            flip_and_time(0, 200, k);
            check(k >= 3 * T + 4, "R7 count restarted after revert", k, 3 * T + 4);
        end

        // R9: disable during qualification
        reg_write('h08, 1000);
        idle(8);
        begin
            logic nv;
            nv = ~dout[0];
            din[0] = nv;
            idle(50);
            check(dout[0] != nv, "R9 still qualifying", int'(dout[0]), int'(~nv));
            reg_write('h44, 0);
            idle(3);
            check(dout[0] == nv, "R9 disable releases output", int'(dout[0]), int'(nv));
        end

        // R5: return everything to pass-through with interval 0 and enables set
        reg_write('h08, 0);
        reg_write('h44 + 48, 32'h0000_00FF);
        idle(4);
        flip_and_time(30, 50, k);
        check(k == 3, "R5 enabled with interval zero", k, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule